// File: doc/BRIEF.md
# Three-Rail Power-Up and Fault Sequencer

This block brings up a board's three supplies in a fixed order and takes them down again when a rail fails or software asks. It watches a main-supply-good flag, the good flags of a 3.3 V rail and a 2.5 V rail, and a power-off request level. It drives an enable for each of the two lower rails and a fault flag. Every input passes a two-flop synchroniser before the state machine looks at it, so the flags may come straight from comparators in another clock domain.

A bring-up starts once the power-off request is low and the main supply is good. The 3.3 V rail is switched on first. The 2.5 V rail follows once the 3.3 V flag reports good. The block then holds in its power-good state. Each enable step has its own timeout, counted in periods of an external tick strobe. If the rail does not come up in time, the sequence goes to a drop state. A rail dropping while power is good sends the machine through two diagnosis states, which find the failing rail and choose the drop state. Every drop state returns to the first idle state after a hold time.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the outputs `{en33_o, en25_o, fault_o}` read 000 and the machine sits in its first idle state.
- R2: Every input, including `tick_i`, is registered twice before use. A change on an input can change the outputs no earlier than the third rising edge after it.
- R3: The first idle state moves to the second idle state when the power-off request is low. The second idle state goes back to the first when the request is high, even if the main supply is good. Otherwise it starts the 3.3 V step when the main supply is good. Both idle states output 000.
- R4: The 3.3 V step outputs 100. It moves to the 2.5 V step when the 3.3 V good flag is high. This takes priority over its timeout.
- R5: The 2.5 V step outputs 110. It moves to the power-good state when the 2.5 V good flag is high. The power-good state also outputs 110.
- R6: A step timeout counts synchronised ticks from the entry into the step, and the count restarts at every state change. The 3.3 V step goes to drop state A (output 011) after `RAMP_A_TICKS` ticks. The 2.5 V step goes to drop state B (output 101) after `RAMP_B_TICKS` ticks.
- R7: In the power-good state, any of the three good flags low moves to the first diagnosis state, even when the power-off request is also high. With all flags good, a high power-off request moves to drop state B.
- R8: Both diagnosis states output 111 and each lasts one cycle. The first goes to drop state A if the main supply is low, and to the second diagnosis state otherwise. The second goes to drop state A if the 3.3 V flag is low, and to drop state B otherwise, which means the 2.5 V rail failed.
- R9: Both drop states return to the first idle state after `DROP_TICKS` ticks.
- R10: The output code 001 (fault with both enables off) never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| tick_i | input | 1 | Time-base strobe, one pulse per timer period |
| main_good_i | input | 1 | Main (5 V) supply good |
| r33_good_i | input | 1 | 3.3 V rail good |
| r25_good_i | input | 1 | 2.5 V rail good |
| off_req_i | input | 1 | Power-off request level, high asks for power-down |
| en33_o | output | 1 | 3.3 V rail enable |
| en25_o | output | 1 | 2.5 V rail enable |
| fault_o | output | 1 | Fault flag |

## Verification
The embedded properties check on every cycle that the 3.3 V step is entered only from the second idle state under the start condition, and that drop state A is reached from the 3.3 V step only on an expired timer. They also check that the tick counter restarts on each state change and advances only on a tick, that the second diagnosis state always follows the first, that power-good is left only toward diagnosis or drop state B, and that the 001 output code never appears. The order in which rails are enabled, the exact synchroniser latency, the length of each timeout and drop hold, and which drop state each failing rail leads to depend on stimulus history. Only the bench's scenarios can show those, checked against its cycle-by-cycle reference model.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [3:0] {
    ST_HOLD   = 4'd0,
    ST_ARM    = 4'd1,
    ST_RAMP_A = 4'd2,
    ST_RAMP_B = 4'd3,
    ST_GOOD   = 4'd4,
    ST_DIAG1  = 4'd5,
    ST_DIAG2  = 4'd6,
    ST_DROP_A = 4'd7,
    ST_DROP_B = 4'd8
  } seq_state_e;

  typedef enum logic [1:0] {
    LIM_RAMP_A = 2'd0,
    LIM_RAMP_B = 2'd1,
    LIM_DROP   = 2'd2,
    LIM_NONE   = 2'd3
  } lim_sel_e;

  typedef struct packed {
    logic en33;
    logic en25;
    logic fault;
  } rail_out_t;

  localparam int unsigned SYNC_W = 5;

  function automatic rail_out_t decode_out(seq_state_e s);
    rail_out_t o;
    case (s)
      ST_RAMP_A: o = 3'b100;
      ST_RAMP_B: o = 3'b110;
      ST_GOOD:   o = 3'b110;
      ST_DIAG1:  o = 3'b111;
      ST_DIAG2:  o = 3'b111;
      ST_DROP_A: o = 3'b011;
      ST_DROP_B: o = 3'b101;
      default:   o = 3'b000;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    for (genvar g = 0; g < STAGES; g++) begin : stage
      logic [W-1:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= '0;
          else        q <= stage[g-1].q;
        end
      end
    end
  endgenerate

  assign q_o = stage[STAGES-1].q;

endmodule

// File: rtl/step_timer.sv
module step_timer
  import rail_seq_pkg::*;
#(
  parameter int unsigned RAMP_A_TICKS = 1000,
  parameter int unsigned RAMP_B_TICKS = 2000,
  parameter int unsigned DROP_TICKS   = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     tick_i,
  input  lim_sel_e sel_i,
  output logic     expired_o
);

  localparam int unsigned MAX_AB  = (RAMP_A_TICKS > RAMP_B_TICKS) ? RAMP_A_TICKS : RAMP_B_TICKS;
  localparam int unsigned MAX_ALL = (MAX_AB > DROP_TICKS) ? MAX_AB : DROP_TICKS;
  localparam int unsigned CW      = $clog2(MAX_ALL + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          cnt_en;
  logic          past_valid;

  always_comb begin
    case (sel_i)
      LIM_RAMP_A: lim = CW'(RAMP_A_TICKS);
      LIM_RAMP_B: lim = CW'(RAMP_B_TICKS);
      LIM_DROP:   lim = CW'(DROP_TICKS);
      default:    lim = '1;
    endcase
  end

  assign cnt_en = clr_i | (tick_i & (cnt_q < lim));

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R6: the count restarts on every state change
  a_r6_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(clr_i)) |-> (cnt_q == '0));

  // R6: the count only ever steps by one, and only on a tick
  a_r6_count_by_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(clr_i) && (cnt_q != $past(cnt_q)))
      |-> ($past(tick_i) && (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import rail_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      main_s,
  input  logic      r33_s,
  input  logic      r25_s,
  input  logic      off_s,
  input  logic      expired_i,
  output logic      clr_o,
  output lim_sel_e  sel_o,
  output rail_out_t out_o
);

  seq_state_e state_q, state_d;
  logic       all_good;
  logic       past_valid;

  assign all_good = main_s & r33_s & r25_s;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HOLD:   if (!off_s) state_d = ST_ARM;
      ST_ARM: begin
        if (off_s)       state_d = ST_HOLD;
        else if (main_s) state_d = ST_RAMP_A;
      end
      ST_RAMP_A: begin
        if (r33_s)          state_d = ST_RAMP_B;
        else if (expired_i) state_d = ST_DROP_A;
      end
      ST_RAMP_B: begin
        if (r25_s)          state_d = ST_GOOD;
        else if (expired_i) state_d = ST_DROP_B;
      end
      ST_GOOD: begin
        if (!all_good)  state_d = ST_DIAG1;
        else if (off_s) state_d = ST_DROP_B;
      end
      ST_DIAG1:  state_d = main_s ? ST_DIAG2 : ST_DROP_A;
      ST_DIAG2:  state_d = r33_s  ? ST_DROP_B : ST_DROP_A;
      ST_DROP_A: if (expired_i) state_d = ST_HOLD;
      ST_DROP_B: if (expired_i) state_d = ST_HOLD;
      default:   state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_HOLD;
    else        state_q <= state_d;
  end

  always_comb begin
    case (state_q)
      ST_RAMP_A:            sel_o = LIM_RAMP_A;
      ST_RAMP_B:            sel_o = LIM_RAMP_B;
      ST_DROP_A, ST_DROP_B: sel_o = LIM_DROP;
      default:              sel_o = LIM_NONE;
    endcase
  end

  assign clr_o = (state_d != state_q);
  assign out_o = decode_out(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R3: the 3.3 V step starts only from the second idle state with the start condition met
  a_r3_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && state_q == ST_RAMP_A && $past(state_q) != ST_RAMP_A)
      |-> ($past(state_q) == ST_ARM && $past(main_s) && !$past(off_s)));

  // R6: leaving the 3.3 V step for drop state A needs an expired timer
  a_r6_timeout_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && state_q == ST_DROP_A && $past(state_q) == ST_RAMP_A)
      |-> $past(expired_i));

  // R7: power-good is left only toward diagnosis or drop state B
  a_r7_good_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(state_q) == ST_GOOD && state_q != ST_GOOD)
      |-> (state_q == ST_DIAG1 || state_q == ST_DROP_B));

  // R8: the second diagnosis state always follows the first
  a_r8_diag_order: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && state_q == ST_DIAG2) |-> ($past(state_q) == ST_DIAG1));

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int unsigned RAMP_A_TICKS = 1000,
  parameter int unsigned RAMP_B_TICKS = 2000,
  parameter int unsigned DROP_TICKS   = 1000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic main_good_i,
  input  logic r33_good_i,
  input  logic r25_good_i,
  input  logic off_req_i,
  output logic en33_o,
  output logic en25_o,
  output logic fault_o
);

  logic [SYNC_W-1:0] raw_in, syn_in;
  logic              clr, expired;
  lim_sel_e          sel;
  rail_out_t         outs;

  assign raw_in = {tick_i, off_req_i, r25_good_i, r33_good_i, main_good_i};

  rail_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_s    (syn_in[0]),
    .r33_s     (syn_in[1]),
    .r25_s     (syn_in[2]),
    .off_s     (syn_in[3]),
    .expired_i (expired),
    .clr_o     (clr),
    .sel_o     (sel),
    .out_o     (outs)
  );

  step_timer #(
    .RAMP_A_TICKS (RAMP_A_TICKS),
    .RAMP_B_TICKS (RAMP_B_TICKS),
    .DROP_TICKS   (DROP_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .tick_i    (syn_in[4]),
    .sel_i     (sel),
    .expired_o (expired)
  );

  assign en33_o  = outs.en33;
  assign en25_o  = outs.en25;
  assign fault_o = outs.fault;

  // R10: fault is never raised with both enables off
  a_r10_no_lone_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_o && !en33_o && !en25_o));

endmodule

// File: tb/sim_rail_seq_ctrl.sv
module sim_rail_seq_ctrl;

  localparam int TA = 6;
  localparam int TB = 9;
  localparam int TD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic main_g = 1'b0, g33 = 1'b0, g25 = 1'b0, off = 1'b0;
  logic en33, en25, flt;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int tcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rail_seq_ctrl #(.RAMP_A_TICKS(TA), .RAMP_B_TICKS(TB), .DROP_TICKS(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .main_good_i(main_g),
    .r33_good_i(g33), .r25_good_i(g25), .off_req_i(off),
    .en33_o(en33), .en25_o(en25), .fault_o(flt)
  );

  // tick strobe: one cycle in four
  always @(negedge clk) begin
    tick = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
  end

  // reference model: 0 idle1,1 idle2,2 step33,3 step25,4 good,5 diag1,6 diag2,7 dropA,8 dropB
  int m_st = 0;
  int m_cnt = 0;
  logic [4:0] pipe[$] = '{5'd0, 5'd0};

  function automatic logic [2:0] exp_out(int s);
    case (s)
      2: return 3'b100;
      3, 4: return 3'b110;
      5, 6: return 3'b111;
      7: return 3'b011;
      8: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
      pipe = '{5'd0, 5'd0};
    end else begin
      logic [4:0] s;
      int lim, ns;
      s = pipe[0];
      lim = (m_st == 2) ? TA : (m_st == 3) ? TB : (m_st == 7 || m_st == 8) ? TD : 1 << 20;
      ns = m_st;
      case (m_st)
        0: if (!s[3]) ns = 1;
        1: if (s[3]) ns = 0; else if (s[0]) ns = 2;
        2: if (s[1]) ns = 3; else if (m_cnt >= lim) ns = 7;
        3: if (s[2]) ns = 4; else if (m_cnt >= lim) ns = 8;
        4: if (!(s[0] && s[1] && s[2])) ns = 5; else if (s[3]) ns = 8;
        5: ns = s[0] ? 6 : 7;
        6: ns = s[1] ? 8 : 7;
        default: if (m_cnt >= lim) ns = 0;
      endcase
      if (ns != m_st) m_cnt = 0;
      else if (s[4] && m_cnt < lim) m_cnt++;
      m_st = ns;
      void'(pipe.pop_front());
      pipe.push_back({tick, off, g25, g33, main_g});
    end
  end

  // per-cycle comparison against the model (R10 code legality covered too)
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] e;
      e = exp_out(m_st);
      checks++;
      if ({en33, en25, flt} !== e) begin
        fails++;
        $display("FAIL R10 model state %0d: actual %b expected %b", m_st, {en33, en25, flt}, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] e);
    checks++;
    if ({en33, en25, flt} !== e) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, {en33, en25, flt}, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    off = 1'b1; main_g = 1'b0; g33 = 1'b0; g25 = 1'b0;
    cyc(80);
  endtask

  task automatic bring_up();
    main_g = 1'b1; g33 = 1'b1; g25 = 1'b1; off = 1'b0;
    cyc(6);
    chk("R5 power good", 3'b110);
  endtask

  initial begin
    cyc(3);
    chk("R1 in reset", 3'b000);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 after reset", 3'b000);
    cyc(4);
    // idle2 reached (off low); start with main good
    main_g = 1'b1;
    cyc(2);
    chk("R2 no output before third edge", 3'b000);
    cyc(1);
    chk("R4 step33 enabled", 3'b100);
    g33 = 1'b1;
    cyc(3);
    chk("R4 step25 after 3.3 good", 3'b110);
    g25 = 1'b1;
    cyc(3);
    chk("R5 power good", 3'b110);
    off = 1'b1;
    cyc(3);
    chk("R7 power-off to drop B", 3'b101);
    cyc(60);
    chk("R9 drop returns to idle", 3'b000);
    cyc(30);
    chk("R3 off high holds idle", 3'b000);

    // R3: idle2 with off and main good together returns to idle1
    go_idle();
    off = 1'b0;
    cyc(6);
    off = 1'b1; main_g = 1'b1;
    cyc(20);
    chk("R3 off beats start in idle2", 3'b000);

    // R6: step33 timeout
    go_idle();
    main_g = 1'b1; off = 1'b0;
    cyc(4);
    chk("R4 step33 entered", 3'b100);
    cyc(28);
    chk("R6 step33 timeout to drop A", 3'b011);
    go_idle();

    // R6: step25 timeout
    main_g = 1'b1; g33 = 1'b1; off = 1'b0;
    cyc(5);
    chk("R5 step25 entered", 3'b110);
    cyc(45);
    chk("R6 step25 timeout to drop B", 3'b101);
    go_idle();

    // R8: 2.5 V rail fails
    bring_up();
    g25 = 1'b0;
    cyc(3);
    chk("R8 diag1", 3'b111);
    cyc(1);
    chk("R8 diag2", 3'b111);
    cyc(1);
    chk("R8 2.5 V fault to drop B", 3'b101);
    go_idle();

    // R8: main supply fails
    bring_up();
    main_g = 1'b0;
    cyc(3);
    chk("R8 diag1 main", 3'b111);
    cyc(1);
    chk("R8 main fault to drop A", 3'b011);
    go_idle();

    // R8: 3.3 V rail fails
    bring_up();
    g33 = 1'b0;
    cyc(4);
    chk("R8 diag2 3.3", 3'b111);
    cyc(1);
    chk("R8 3.3 V fault to drop A", 3'b011);
    go_idle();

    // R7: fault beats power-off request
    bring_up();
    g25 = 1'b0; off = 1'b1;
    cyc(3);
    chk("R7 fault priority over off", 3'b111);
    go_idle();

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule